// File: doc/BRIEF.md
# Bounds-Checked Misaligned Load/Store Splitter

This block sits between the load/store execute stage and a data-memory port that only takes aligned word transfers. Each request brings a byte address, a size and a pair of capability bounds: a base that is as wide as the address and a top that is one bit wider. The block decides once, from the starting address, whether the access is in bounds. If it is, the block drives one aligned bus transfer, or two when the bytes straddle a word boundary. It then reports the outcome with a single completion pulse that carries the merged load data.

A rejected request produces a one-cycle error pulse, and the bus is never touched. The sequencer stays idle, so a second half cannot follow a failed check. An access whose second word would lie past the last word of the address space is always rejected, whatever top value is supplied. This closes the path by which a wrapped second half could reach address zero without a check.

Top module: `bnd_split_lsu`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_req_o`, `done_o` and `err_o` are low and `req_ready_o` is high.
- R2: The check treats every access as a full word, whatever its size. A request passes only when `addr >= base` and `addr + 4 <= top`, with `top` taken as a 33-bit value. A top below 4 rejects every address.
- R3: A rejected request raises `err_o` for exactly one cycle, in the cycle after the request is sampled. It issues no bus request, and `req_ready_o` stays high.
- R4: A request that splits while its first word is 0xFFFF_FFFC is rejected, even when top is above 0x1_0000_0000.
- R5: An access splits only in two cases: a halfword at byte offset 3, or a word at byte offset 1, 2 or 3. Every other access makes exactly one bus transfer.
- R6: `mem_be_o` bit i enables byte lane i, which is data bits 8i+7..8i. The first transfer enables the lanes from the start offset upward. The second enables the remaining lanes from lane 0 upward.
- R7: The first transfer goes to the start address with its two low bits cleared. The second goes to that address plus 4.
- R8: A raised `mem_req_o` stays high, with address, byte enables and write data unchanged, until the cycle in which `mem_gnt_i` is high.
- R9: A load completes with one `done_o` pulse, one cycle after the last `mem_rvalid_i`. `rdata_o` then holds the bytes in little-endian order, starting at bit 0 and zero-extended above the access size.
- R10: Store data byte k appears on the lane of byte address start+k. Lanes 4 and up wrap into the second transfer.
- R11: `req_size_i` encodes 0 as byte, 1 as halfword, and both 2 and 3 as word.
- R12: `req_ready_o` is high only while the sequencer is idle. It drops in the cycle after an in-bounds request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present (taken while ready) |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte start address |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Store data, least significant byte first |
| cap_base_i | input | 32 | Lowest permitted address |
| cap_top_i | input | 33 | One past the highest permitted address |
| req_ready_o | output | 1 | Sequencer idle |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Bounds error pulse |
| rdata_o | output | 32 | Merged load result |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write |
| mem_addr_o | output | 32 | Aligned bus address |
| mem_be_o | output | 4 | Bus byte enables |
| mem_wdata_o | output | 32 | Bus write data |
| mem_gnt_i | input | 1 | Bus grant |
| mem_rvalid_i | input | 1 | Bus response valid |
| mem_rdata_i | input | 32 | Bus read data |

## Verification
Each size is tried at every byte offset, for both loads and stores. This separates the single-transfer cases from the split ones and shows whether the lanes, the second address and the merged load bytes are right. A second group places requests on the bounds themselves: the address equal to the base, one byte below the base, a word exactly at top minus 4, and a byte just above it. These tell the full-word check apart from a check that uses the access size. A third group targets the last word of the address space. It pairs the normal top with an oversized top, and aligned with misaligned starts, so that the wrap rejection is separated from the ordinary top comparison. A grant that always lags by one cycle tests that the request is held steady.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ1  = 3'd1,
    ST_WAIT1 = 3'd2,
    ST_REQ2  = 3'd3,
    ST_WAIT2 = 3'd4
  } bsl_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/bsl_lane_gen.sv
module bsl_lane_gen
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              split_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [ADDR_W-1:0] wa0_o,
  output logic [ADDR_W-1:0] wa1_o,
  output logic [BYTES-1:0]  be0_o,
  output logic [BYTES-1:0]  be1_o,
  output logic [DATA_W-1:0] wd0_o,
  output logic [DATA_W-1:0] wd1_o,
  output logic [DATA_W-1:0] keep_o
);
  localparam int LW = OFF_W + 2;

  logic [LW-1:0]         off_x;
  logic [LW-1:0]         nbytes;
  logic [LW-1:0]         end_x;
  logic [2*BYTES-1:0]    lane_en;
  logic [2*DATA_W-1:0]   wide;

  assign off_o  = addr_i[OFF_W-1:0];
  assign off_x  = {2'b00, addr_i[OFF_W-1:0]};
  assign nbytes = (size_i == SZ_BYTE) ? LW'(1) :
                  (size_i == SZ_HALF) ? LW'(2) : LW'(BYTES);
  assign end_x  = off_x + nbytes;

  // one flag per lane across two consecutive words
  for (genvar i = 0; i < 2 * BYTES; i++) begin : g_lane
    assign lane_en[i] = (LW'(i) >= off_x) && (LW'(i) < end_x);
  end

  // zero-extension mask for the merged load result
  for (genvar j = 0; j < BYTES; j++) begin : g_keep
    assign keep_o[8*j +: 8] = {8{LW'(j) < nbytes}};
  end

  assign be0_o   = lane_en[BYTES-1:0];
  assign be1_o   = lane_en[2*BYTES-1:BYTES];
  assign split_o = |lane_en[2*BYTES-1:BYTES];

  assign wide  = {{DATA_W{1'b0}}, wdata_i} << {off_o, 3'b000};
  assign wd0_o = wide[DATA_W-1:0];
  assign wd1_o = wide[2*DATA_W-1:DATA_W];

  assign wa0_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wa1_o = wa0_o + ADDR_W'(BYTES);
endmodule

// File: rtl/bsl_bound_chk.sv
module bsl_bound_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   top_i,
  input  logic              split_i,
  output logic              ok_o
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W + 1)'(BYTES);

  logic              top_small;
  logic [ADDR_W:0]   top_lim;
  logic              last_word;
  logic              above_base;
  logic              below_top;

  assign top_small  = top_i < SPAN;
  assign top_lim    = top_i - SPAN;
  assign above_base = addr_i >= base_i;
  assign below_top  = !top_small && ({1'b0, addr_i} <= top_lim);
  // a split starting in the last word would wrap its second half to zero
  assign last_word  = &addr_i[ADDR_W-1:OFF_W];

  assign ok_o = above_base && below_top && !(split_i && last_word);
endmodule

// File: rtl/bsl_seq.sv
module bsl_seq
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              chk_ok_i,
  input  logic              split_i,
  input  logic [ADDR_W-1:0] wa0_i,
  input  logic [ADDR_W-1:0] wa1_i,
  input  logic [BYTES-1:0]  be0_i,
  input  logic [BYTES-1:0]  be1_i,
  input  logic [DATA_W-1:0] wd0_i,
  input  logic [DATA_W-1:0] wd1_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] keep_i,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  bsl_state_e          state;
  logic                split_q;
  logic [ADDR_W-1:0]   wa1_q;
  logic [BYTES-1:0]    be1_q;
  logic [DATA_W-1:0]   wd1_q;
  logic [OFF_W-1:0]    off_q;
  logic [DATA_W-1:0]   keep_q;
  logic [DATA_W-1:0]   lo_q;
  logic [2*DATA_W-1:0] cat;
  logic [DATA_W-1:0]   merged;

  assign req_ready_o = (state == ST_IDLE);

  assign cat    = (state == ST_WAIT2) ? {mem_rdata_i, lo_q}
                                      : {{DATA_W{1'b0}}, mem_rdata_i};
  assign merged = DATA_W'(cat >> {off_q, 3'b000}) & keep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      rdata_o     <= '0;
      split_q     <= 1'b0;
      wa1_q       <= '0;
      be1_q       <= '0;
      wd1_q       <= '0;
      off_q       <= '0;
      keep_q      <= '0;
      lo_q        <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (!chk_ok_i) begin
              err_o <= 1'b1;            // stay idle: no half is ever issued
            end else begin
              mem_req_o   <= 1'b1;
              mem_we_o    <= req_we_i;
              mem_addr_o  <= wa0_i;
              mem_be_o    <= be0_i;
              mem_wdata_o <= wd0_i;
              split_q     <= split_i;
              wa1_q       <= wa1_i;
              be1_q       <= be1_i;
              wd1_q       <= wd1_i;
              off_q       <= off_i;
              keep_q      <= keep_i;
              state       <= ST_REQ1;
            end
          end
        end
        ST_REQ1: begin
          if (mem_gnt_i) begin
            mem_req_o <= 1'b0;
            state     <= ST_WAIT1;
          end
        end
        ST_WAIT1: begin
          if (mem_rvalid_i) begin
            lo_q <= mem_rdata_i;
            if (split_q) begin
              mem_req_o   <= 1'b1;
              mem_addr_o  <= wa1_q;
              mem_be_o    <= be1_q;
              mem_wdata_o <= wd1_q;
              state       <= ST_REQ2;
            end else begin
              done_o  <= 1'b1;
              rdata_o <= merged;
              state   <= ST_IDLE;
            end
          end
        end
        ST_REQ2: begin
          if (mem_gnt_i) begin
            mem_req_o <= 1'b0;
            state     <= ST_WAIT2;
          end
        end
        ST_WAIT2: begin
          if (mem_rvalid_i) begin
            done_o  <= 1'b1;
            rdata_o <= merged;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!mem_req_o && req_ready_o));

  assert_hold_until_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_be_o) && $stable(mem_wdata_o)));

  assert_done_after_traffic_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_req_o && req_ready_o));

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> !req_ready_o);
endmodule

// File: rtl/bnd_split_lsu.sv
module bnd_split_lsu #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [ADDR_W-1:0] cap_base_i,
  input  logic [ADDR_W:0]   cap_top_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              split;
  logic              chk_ok;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] wa0, wa1;
  logic [BYTES-1:0]  be0, be1;
  logic [DATA_W-1:0] wd0, wd1, keep;

  bsl_lane_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .wdata_i (req_wdata_i),
    .split_o (split),
    .off_o   (off),
    .wa0_o   (wa0),
    .wa1_o   (wa1),
    .be0_o   (be0),
    .be1_o   (be1),
    .wd0_o   (wd0),
    .wd1_o   (wd1),
    .keep_o  (keep)
  );

  bsl_bound_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .addr_i  (req_addr_i),
    .base_i  (cap_base_i),
    .top_i   (cap_top_i),
    .split_i (split),
    .ok_o    (chk_ok)
  );

  bsl_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_we_i     (req_we_i),
    .chk_ok_i     (chk_ok),
    .split_i      (split),
    .wa0_i        (wa0),
    .wa1_i        (wa1),
    .be0_i        (be0),
    .be1_i        (be1),
    .wd0_i        (wd0),
    .wd1_i        (wd1),
    .off_i        (off),
    .keep_i       (keep),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o)
  );

  assert_lanes_present_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_be_o != '0));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, err_o}));
endmodule

// File: tb/bnd_split_lsu_bench.sv
module bnd_split_lsu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid_i, req_we_i;
  logic [31:0] req_addr_i, req_wdata_i, cap_base_i;
  logic [1:0]  req_size_i;
  logic [32:0] cap_top_i;
  logic        req_ready_o, done_o, err_o;
  logic [31:0] rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_rdata_i;

  always #4ns clk = ~clk;   // 125 MHz

  bnd_split_lsu u_bnd_split_lsu (.*);

  typedef struct {logic [31:0] addr; logic [3:0] be; logic we; logic [31:0] wd; string tag;} bus_t;
  typedef struct {logic err; logic we; logic [31:0] rd; string tag;} cpl_t;

  bus_t exp_bus[$];
  cpl_t exp_cpl[$];
  int   n_chk = 0;
  int   n_err = 0;

  task automatic check(bit cond, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(logic [31:0] a);
    return {a[31:24] ^ 8'hA9, a[23:16] ^ 8'h77, a[15:8] ^ 8'h1E, a[7:0] ^ 8'hC3};
  endfunction

  // driver: computes expectations from the requirements and pushes them
  task automatic access(bit we, logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                        logic [31:0] base, logic [32:0] top, string tag);
    int n, off;
    bit split, ok;
    logic [3:0] be1, be2;
    logic [31:0] wd1, wd2, rd, w0, w1, p0, p1;
    bus_t b;
    cpl_t c;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;           // R11
    off = int'(a[1:0]);
    split = (off + n) > 4;                                   // R5
    w0 = {a[31:2], 2'b00};                                   // R7
    w1 = w0 + 32'd4;
    ok = (a >= base) && (({2'b00, a} + 34'd4) <= {1'b0, top})   // R2
         && !(split && w0 == 32'hFFFF_FFFC);                 // R4
    be1 = '0; be2 = '0; wd1 = '0; wd2 = '0; rd = '0;
    p0 = pat(w0); p1 = pat(w1);
    for (int i = 0; i < n; i++) begin
      int ln = off + i;
      if (ln < 4) begin
        be1[ln] = 1'b1; wd1[8*ln +: 8] = wd[8*i +: 8]; rd[8*i +: 8] = p0[8*ln +: 8];
      end else begin
        be2[ln-4] = 1'b1; wd2[8*(ln-4) +: 8] = wd[8*i +: 8]; rd[8*i +: 8] = p1[8*(ln-4) +: 8];
      end
    end
    if (ok) begin
      b.addr = w0; b.be = be1; b.we = we; b.wd = wd1; b.tag = tag; exp_bus.push_back(b);
      if (split) begin
        b.addr = w1; b.be = be2; b.wd = wd2; exp_bus.push_back(b);
      end
    end
    c.err = !ok; c.we = we; c.rd = rd; c.tag = tag;
    exp_cpl.push_back(c);

    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_size_i = sz;
    req_wdata_i = wd; cap_base_i = base; cap_top_i = top;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(req_ready_o == !ok, "R12", "ready after accept", 64'(req_ready_o), 64'(!ok));
    while (exp_cpl.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);   // window for stray bus traffic after an error
  endtask

  // memory responder and bus monitor: grant one cycle late, data the cycle after
  bit          seen;
  logic [31:0] s_addr, s_wd, g_addr;
  logic [3:0]  s_be;
  initial begin
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0; seen = 1'b0;
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      if (mem_gnt_i) begin
        mem_gnt_i = 1'b0; mem_rvalid_i = 1'b1; mem_rdata_i = pat(g_addr);
      end else if (mem_req_o && !rst) begin
        if (!seen) begin
          seen = 1'b1; s_addr = mem_addr_o; s_be = mem_be_o; s_wd = mem_wdata_o;
        end else begin
          seen = 1'b0;
          check(mem_addr_o == s_addr && mem_be_o == s_be && mem_wdata_o == s_wd,
                "R8", "request held", 64'(mem_addr_o), 64'(s_addr));
          if (exp_bus.size() == 0) begin
            check(1'b0, "R3", "unexpected bus request", 64'(mem_addr_o), 64'd0);
          end else begin
            bus_t e;
            logic [31:0] m;
            e = exp_bus.pop_front();
            m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
            check(mem_addr_o == e.addr, {e.tag, " R7"}, "bus address", 64'(mem_addr_o), 64'(e.addr));
            check(mem_be_o == e.be, {e.tag, " R6"}, "byte enables", 64'(mem_be_o), 64'(e.be));
            check(mem_we_o == e.we, e.tag, "write flag", 64'(mem_we_o), 64'(e.we));
            if (e.we)
              check((mem_wdata_o & m) == e.wd, {e.tag, " R10"}, "store lanes",
                    64'(mem_wdata_o & m), 64'(e.wd));
          end
          g_addr = mem_addr_o;
          mem_gnt_i = 1'b1;
        end
      end
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (done_o || err_o)) begin
        if (exp_cpl.size() == 0) begin
          check(1'b0, "R9", "unexpected completion", {62'd0, err_o, done_o}, 64'd0);
        end else begin
          cpl_t c;
          c = exp_cpl.pop_front();
          check(err_o == c.err && done_o == !c.err, {c.tag, " R3"}, "outcome {err,done}",
                {62'd0, err_o, done_o}, {62'd0, c.err, !c.err});
          if (!c.err && !c.we)
            check(rdata_o == c.rd, {c.tag, " R9"}, "load data", 64'(rdata_o), 64'(c.rd));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not end", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid_i = 1'b0; req_we_i = 1'b0; req_addr_i = '0;
    req_size_i = '0; req_wdata_i = '0; cap_base_i = '0; cap_top_i = '0;
    repeat (3) @(negedge clk);
    check(!mem_req_o && !done_o && !err_o && req_ready_o, "R1", "reset state",
          {60'd0, mem_req_o, done_o, err_o, req_ready_o}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_req_o && !done_o && !err_o && req_ready_o, "R1", "after reset",
          {60'd0, mem_req_o, done_o, err_o, req_ready_o}, 64'd1);

    // all sizes at all offsets, loads then stores (R5 R6 R9 R10)
    for (int sz = 0; sz < 3; sz++)
      for (int o = 0; o < 4; o++) begin
        access(1'b0, 32'h0000_1010 + 32'(o), 2'(sz), 32'h0, 32'h1000, 33'h0_0000_2000, "R5");
        access(1'b1, 32'h0000_1020 + 32'(o), 2'(sz), 32'hD4C3_B2A1, 32'h1000, 33'h0_0000_2000, "R10");
      end
    access(1'b0, 32'h0000_1031, 2'd3, 32'h0, 32'h1000, 33'h0_0000_2000, "R11");
    access(1'b0, 32'h0000_1034, 2'd3, 32'h0, 32'h1000, 33'h0_0000_2000, "R11");

    // bounds edges (R2)
    access(1'b0, 32'h0000_1000, 2'd2, 32'h0, 32'h1000, 33'h0_0000_2000, "R2");
    access(1'b0, 32'h0000_0FFF, 2'd0, 32'h0, 32'h1000, 33'h0_0000_2000, "R2");
    access(1'b0, 32'h0000_1FFC, 2'd2, 32'h0, 32'h1000, 33'h0_0000_2000, "R2");
    access(1'b0, 32'h0000_1FFD, 2'd0, 32'h0, 32'h1000, 33'h0_0000_2000, "R2");
    access(1'b1, 32'h0000_1FFB, 2'd1, 32'h1234, 32'h1000, 33'h0_0000_2000, "R2");
    access(1'b0, 32'h0000_0000, 2'd0, 32'h0, 32'h0, 33'h0_0000_0002, "R2");

    // top of the address space (R4)
    access(1'b0, 32'hFFFF_FFFC, 2'd2, 32'h0, 32'hFFFF_0000, 33'h1_0000_0000, "R4");
    access(1'b0, 32'hFFFF_FFFD, 2'd2, 32'h0, 32'hFFFF_0000, 33'h1_0000_0000, "R4");
    access(1'b1, 32'hFFFF_FFFF, 2'd2, 32'h55AA_55AA, 32'hFFFF_FFFC, 33'h1_0000_0000, "R4");
    access(1'b0, 32'hFFFF_FFFD, 2'd2, 32'h0, 32'hFFF0_8000, 33'h1_FFFF_0FFC, "R4");
    access(1'b0, 32'hFFFF_FFFE, 2'd2, 32'h0, 32'hFFF0_8000, 33'h1_FFFF_0FFC, "R4");
    access(1'b0, 32'hFFFF_FFFF, 2'd1, 32'h0, 32'hFFF0_8000, 33'h1_FFFF_0FFC, "R4");
    access(1'b0, 32'hFFFF_FFFF, 2'd0, 32'h0, 32'hFFF0_8000, 33'h1_FFFF_0FFC, "R4");
    access(1'b0, 32'hFFFF_FFFE, 2'd1, 32'h0, 32'hFFF0_8000, 33'h1_FFFF_0FFC, "R4");

    repeat (5) @(negedge clk);
    check(exp_bus.size() == 0, "R5", "missing bus transfers", 64'(exp_bus.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule